// File: doc/BRIEF.md
# Stand-alone Phrase Trigger Controller

This block is the pin-side control logic of a voice playback device that runs without a host processor. It watches a six-bit phrase-select bus and an active-low random trigger. When the select bus changes, it waits for the inputs to settle and then asks a playback engine to play the chosen phrase. When the random trigger falls, it asks for a phrase drawn from a free-running pseudo-random generator instead.

The controller sends a one-cycle start pulse and the latched phrase number to the engine. It holds an active-low busy flag until the engine reports completion. The settle interval is counted in ticks of a prescaled system clock, so the same logic fits any clock rate. The active-low reset doubles as the standby input. All inputs pass through a two-flop synchroniser before they are compared or edge-detected.

Top module: `ptc_trigger_ctrl`

## Requirements
- R1: While `rst_ni` is low and after it is released, `busy_no` is 1, `start_o` is 0 and `phrase_o` is 0.
- R2: A change on `sel_i` produces a one-cycle `start_o` with `phrase_o` equal to the new code. The pulse comes SETTLE_TICKS*TICK_DIV+3 cycles after the change, counting the two synchroniser stages.
- R3: Any further change of the counted select bits during the settle interval restarts the interval from the latest change. Only the latest code is started.
- R4: `busy_no` goes low in the same cycle as `start_o`. It stays low until `done_i` is sampled high, and is 1 from the following cycle.
- R5: Only codes 1 to MAX_PHRASE (56) start playback. A settled code of 0, or one above MAX_PHRASE, starts nothing.
- R6: `phrase_o` keeps its last latched value until the next `start_o`.
- R7: A falling edge on `rnd_ni` produces `start_o` within 4 cycles. The `phrase_o` it carries comes from the LFSR, folded into the range 1 to MAX_PHRASE.
- R8: A settled code or a random falling edge that arrives while `busy_no` is low is dropped, not queued. No start follows once `done_i` has released busy.
- R9: While `rnd_ni` is low, bit 0 of `sel_i` is ignored. A change of that bit alone starts nothing, and a settled code is latched with bit 0 as 0.
- R10: Pulling `rst_ni` low at any time at once returns `busy_no` to 1 and `start_o` to 0, and any pending settle interval is cancelled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset and standby |
| sel_i | input | SEL_W (6) | Phrase-select code, bit 0 is the one masked in random mode |
| rnd_ni | input | 1 | Active-low random trigger; low also selects random mode |
| done_i | input | 1 | Playback engine reports the phrase has finished |
| start_o | output | 1 | One-cycle request to start playback |
| phrase_o | output | SEL_W (6) | Latched phrase number for the engine |
| busy_no | output | 1 | Low while a phrase is playing |

## Verification
The select bus is driven with a single clean change, which measures the exact settle latency. It is also driven with a change followed by a second change mid-interval, which separates a restarting timer from one that runs on from the first edge. Codes 0, 57 and 56 probe both ends of the legal range, and changes made while busy show whether requests are dropped or queued. In random mode, toggling bit 0 alone and then a higher bit distinguishes a correctly masked compare from one that ignores the mask. Random falling edges are applied both idle and busy, and a reset is applied during playback to cover standby.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SEL  = 2'd1,
    SRC_RND  = 2'd2
  } src_e;
endpackage

// File: rtl/ptc_sync.sv
module ptc_sync #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/ptc_settle.sv
module ptc_settle #(
  parameter int unsigned W            = 6,
  parameter int unsigned TICK_DIV     = 250000,
  parameter int unsigned SETTLE_TICKS = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] code_i,
  input  logic [W-1:0] mask_i,
  output logic         fire_o,
  output logic [W-1:0] code_o
);
  localparam int unsigned PRE_W = $clog2(TICK_DIV + 1);
  localparam int unsigned CNT_W = $clog2(SETTLE_TICKS + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_TICKS - 1);

  logic [W-1:0]     last_q;
  logic             pend_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] tcnt_q;
  logic             chg;
  logic             tick;

  assign chg  = |((code_i ^ last_q) & mask_i);
  assign tick = pend_q && (pre_q == PRE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      pend_q <= 1'b0;
      pre_q  <= '0;
      tcnt_q <= '0;
    end else begin
      last_q <= code_i;
      if (chg) begin
        pend_q <= 1'b1;
        pre_q  <= '0;
        tcnt_q <= '0;
      end else if (pend_q) begin
        if (tick) begin
          pre_q <= '0;
          if (tcnt_q == CNT_LAST) pend_q <= 1'b0;
          else                    tcnt_q <= tcnt_q + 1'b1;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end

  assign fire_o = tick && !chg && (tcnt_q == CNT_LAST);
  assign code_o = code_i & mask_i;
endmodule

// File: rtl/ptc_rand.sv
module ptc_rand #(
  parameter int unsigned        LFSR_W = 8,
  parameter logic [LFSR_W-1:0]  TAPS   = 8'hB8,
  parameter int unsigned        OUT_W  = 6,
  parameter int unsigned        MAX_V  = 56
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] pick_o
);
  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] fold;

  // Galois form, free running, never all-zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= LFSR_W'(1);
    else         lfsr_q <= {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? TAPS : '0);
  end

  assign fold   = lfsr_q % LFSR_W'(MAX_V);
  assign pick_o = OUT_W'(fold) + OUT_W'(1);
endmodule

// File: rtl/ptc_trigger_ctrl.sv
module ptc_trigger_ctrl
  import ptc_pkg::*;
#(
  parameter int unsigned SEL_W        = 6,
  parameter int unsigned MAX_PHRASE   = 56,
  parameter int unsigned TICK_DIV     = 250000,
  parameter int unsigned SETTLE_TICKS = 16,
  parameter int unsigned LFSR_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             rnd_ni,
  input  logic             done_i,
  output logic             start_o,
  output logic [SEL_W-1:0] phrase_o,
  output logic             busy_no
);
  localparam logic [SEL_W-1:0] MAX_CODE = SEL_W'(MAX_PHRASE);

  logic [SEL_W-1:0] sel_s;
  logic             rnd_s, rnd_q;
  logic [SEL_W-1:0] mask, code;
  logic [SEL_W-1:0] pick;
  logic             fire, fall, sel_ok;
  src_e             src;

  ptc_sync #(.W(SEL_W), .RST_VAL('0)) i_sync_sel (
    .clk_i, .rst_ni, .d_i(sel_i), .q_o(sel_s)
  );
  ptc_sync #(.W(1), .RST_VAL(1'b1)) i_sync_rnd (
    .clk_i, .rst_ni, .d_i(rnd_ni), .q_o(rnd_s)
  );

  // bit 0 is dropped while random mode is held
  assign mask = {{(SEL_W-1){1'b1}}, rnd_s};

  ptc_settle #(.W(SEL_W), .TICK_DIV(TICK_DIV), .SETTLE_TICKS(SETTLE_TICKS)) i_settle (
    .clk_i, .rst_ni, .code_i(sel_s), .mask_i(mask), .fire_o(fire), .code_o(code)
  );

  ptc_rand #(.LFSR_W(LFSR_W), .OUT_W(SEL_W), .MAX_V(MAX_PHRASE)) i_rand (
    .clk_i, .rst_ni, .pick_o(pick)
  );

  assign fall   = rnd_q && !rnd_s;
  assign sel_ok = (code != '0) && (code <= MAX_CODE);

  always_comb begin
    if (fall)                src = SRC_RND;
    else if (fire && sel_ok) src = SRC_SEL;
    else                     src = SRC_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rnd_q    <= 1'b1;
      start_o  <= 1'b0;
      phrase_o <= '0;
      busy_no  <= 1'b1;
    end else begin
      rnd_q   <= rnd_s;
      start_o <= 1'b0;
      if (!busy_no) begin
        if (done_i) busy_no <= 1'b1;
      end else if (src != SRC_NONE) begin
        start_o  <= 1'b1;
        busy_no  <= 1'b0;
        phrase_o <= (src == SRC_RND) ? pick : code;
      end
    end
  end
endmodule

// File: rtl/ptc_checks.sv
module ptc_checks #(
  parameter int unsigned SEL_W      = 6,
  parameter int unsigned MAX_PHRASE = 56
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             done_i,
  input logic             start_o,
  input logic [SEL_W-1:0] phrase_o,
  input logic             busy_no
);
  a_r4_busy_falls_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_no) |-> start_o);

  a_r4_done_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_no && done_i) |=> busy_no);

  a_r8_no_start_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_no && !done_i) |=> !start_o);

  a_r5_phrase_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (phrase_o != '0 && phrase_o <= SEL_W'(MAX_PHRASE)));

  a_r6_phrase_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_o |-> $stable(phrase_o));

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
endmodule

bind ptc_trigger_ctrl ptc_checks #(.SEL_W(SEL_W), .MAX_PHRASE(MAX_PHRASE)) i_ptc_checks (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done_i),
  .start_o(start_o), .phrase_o(phrase_o), .busy_no(busy_no)
);

// File: tb/test_ptc_trigger_ctrl.sv
module test_ptc_trigger_ctrl;
  localparam int SEL_W = 6;
  localparam int MAXP  = 56;
  localparam int TDIV  = 4;
  localparam int STK   = 16;
  localparam int N     = TDIV * STK;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [SEL_W-1:0] sel_i = '0;
  logic             rnd_ni = 1'b1;
  logic             done_i = 1'b0;
  logic             start_o;
  logic [SEL_W-1:0] phrase_o;
  logic             busy_no;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  ptc_trigger_ctrl #(
    .SEL_W(SEL_W), .MAX_PHRASE(MAXP), .TICK_DIV(TDIV), .SETTLE_TICKS(STK), .LFSR_W(8)
  ) i_ptc_trigger_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel_i), .rnd_ni(rnd_ni), .done_i(done_i),
    .start_o(start_o), .phrase_o(phrase_o), .busy_no(busy_no)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_start(input int limit, output int k);
    k = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (start_o) begin k = i; return; end
    end
  endtask

  task automatic pulse_done();
    @(negedge clk) done_i = 1'b1;
    @(negedge clk) done_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(busy_no === 1'b1, "R1", "busy_no in reset", int'(busy_no), 1);
    @(negedge clk) rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy_no === 1'b1 && start_o === 1'b0, "R1", "busy/start after reset", int'({busy_no, start_o}), 2);
    chk(phrase_o === '0, "R1", "phrase_o after reset", int'(phrase_o), 0);
  endtask

  task automatic t_settle();
    int k;
    @(negedge clk) sel_i = 6'd5;
    wait_start(N + 10, k);
    chk(k == N + 3, "R2", "settle latency", k, N + 3);
    chk(phrase_o == 6'd5, "R2", "phrase latched", int'(phrase_o), 5);
    chk(busy_no == 1'b0, "R4", "busy low with start", int'(busy_no), 0);
    repeat (5) @(negedge clk);
    chk(busy_no == 1'b0, "R4", "busy held before done", int'(busy_no), 0);
    pulse_done();
    chk(busy_no == 1'b1, "R4", "busy released after done", int'(busy_no), 1);
    chk(phrase_o == 6'd5, "R6", "phrase kept after done", int'(phrase_o), 5);
  endtask

  task automatic t_restart();
    int k;
    @(negedge clk) sel_i = 6'd10;
    repeat (N / 2) @(negedge clk);
    chk(start_o == 1'b0, "R3", "no start mid interval", int'(start_o), 0);
    sel_i = 6'd11;
    wait_start(N + 10, k);
    chk(k == N + 3, "R3", "latency from last change", k, N + 3);
    chk(phrase_o == 6'd11, "R3", "latest code started", int'(phrase_o), 11);
    pulse_done();
  endtask

  task automatic t_range();
    int k;
    @(negedge clk) sel_i = 6'd0;
    wait_start(N + 10, k);
    chk(k == -1, "R5", "code 0 starts nothing", k, -1);
    @(negedge clk) sel_i = 6'd57;
    wait_start(N + 10, k);
    chk(k == -1, "R5", "code 57 starts nothing", k, -1);
    chk(busy_no == 1'b1, "R5", "busy stays high", int'(busy_no), 1);
    @(negedge clk) sel_i = 6'd56;
    wait_start(N + 10, k);
    chk(k == N + 3, "R5", "code 56 starts", k, N + 3);
    chk(phrase_o == 6'd56, "R5", "phrase 56", int'(phrase_o), 56);
    pulse_done();
  endtask

  task automatic t_busy();
    int k;
    @(negedge clk) sel_i = 6'd3;
    wait_start(N + 10, k);
    chk(k == N + 3, "R8", "setup start", k, N + 3);
    @(negedge clk) sel_i = 6'd9;
    wait_start(N + 10, k);
    chk(k == -1, "R8", "settle dropped while busy", k, -1);
    pulse_done();
    wait_start(N + 10, k);
    chk(k == -1, "R8", "no queued start after done", k, -1);
    chk(phrase_o == 6'd3, "R6", "phrase unchanged", int'(phrase_o), 3);
  endtask

  task automatic t_random();
    int k;
    @(negedge clk) rnd_ni = 1'b0;
    wait_start(8, k);
    chk(k >= 1 && k <= 4, "R7", "random start latency", k, 3);
    chk(phrase_o >= 1 && phrase_o <= MAXP, "R7", "random phrase in range", int'(phrase_o), 1);
    pulse_done();
    // sel is 9; only bit 0 changes
    @(negedge clk) sel_i = 6'd8;
    wait_start(N + 10, k);
    chk(k == -1, "R9", "bit0 change ignored", k, -1);
    @(negedge clk) sel_i = 6'd7;
    wait_start(N + 10, k);
    chk(k == N + 3, "R9", "masked code starts", k, N + 3);
    chk(phrase_o == 6'd6, "R9", "bit0 read as 0", int'(phrase_o), 6);
    @(negedge clk) rnd_ni = 1'b1;
    repeat (4) @(negedge clk);
    rnd_ni = 1'b0;
    wait_start(8, k);
    chk(k == -1, "R8", "random edge dropped while busy", k, -1);
    pulse_done();
    wait_start(N + 10, k);
    chk(k == -1, "R8", "no random start after done", k, -1);
    @(negedge clk) rnd_ni = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_standby();
    int k;
    @(negedge clk) sel_i = 6'd12;
    wait_start(N + 10, k);
    chk(k == N + 3, "R10", "setup start", k, N + 3);
    @(negedge clk) rst_ni = 1'b0;
    sel_i = 6'd0;
    #1;
    chk(busy_no == 1'b1 && start_o == 1'b0, "R10", "reset forces idle", int'({busy_no, start_o}), 2);
    @(negedge clk) rst_ni = 1'b1;
    @(negedge clk) sel_i = 6'd20;
    repeat (N / 2) @(negedge clk);
    rst_ni = 1'b0;
    sel_i  = 6'd0;
    @(negedge clk) rst_ni = 1'b1;
    wait_start(N + 10, k);
    chk(k == -1, "R10", "pending interval cancelled", k, -1);
    chk(phrase_o == '0, "R10", "phrase cleared", int'(phrase_o), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_settle();
    t_restart();
    t_range();
    t_busy();
    t_random();
    t_standby();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule